// File: doc/BRIEF.md
# Reuse-Filtering Cache Front End

This block sits in front of a set-associative cache and decides which lines are allowed into it. Every line that misses everywhere is fetched from the next level and parked in a small fully associative staging store. The main cache receives a line only when that line is requested a second time while it is still parked. Lines that are touched once and never again grow old in the staging store, are pushed out by newer arrivals and are dropped. The main cache therefore holds only lines that have been reused.

Both stores are looked up in the same cycle for every accepted request. A hit in either one answers one cycle later with the stored data. A miss in both moves the controller from `S_IDLE` to `S_FILL`. In that state it raises a miss request to the next level with the line address and takes no new requests. When the fill arrives, the controller returns from `S_FILL` to `S_IDLE`, writes the line into the staging store and answers with the filled data. The block has two states, `S_IDLE` and `S_FILL`, and two transitions: lookup-miss (`S_IDLE` to `S_FILL`) and fill-accept (`S_FILL` to `S_IDLE`). The block keeps one data word per line. It does not write back dirty data and does not handle coherence.

Top module: `reuse_filter_cache`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `miss_valid` are 0. Both stores are empty, so the first request to any line misses.
- R2: If an accepted request misses in both stores, then from the next cycle `miss_valid` is 1 and `miss_line` is the request address with the low 6 bits removed. Both stay steady and `req_ready` stays 0 until `fill_valid` is seen.
- R3: The cycle after `fill_valid` is accepted, `resp_valid` is 1, `resp_hit` is 0 and `resp_data` equals `fill_data`. The line goes into the staging store only, so the next request to that line is answered from the staging store (`resp_from_main`=0).
- R4: A request that hits the staging store is answered one cycle later with `resp_hit`=1, `resp_from_main`=0 and the stored data. The line is moved into the main cache, so the next request to it is answered from the main cache (`resp_from_main`=1).
- R5: Moving a line to the main cache frees its staging entry. With the staging store full, one such move followed by one new fill evicts none of the other three parked lines.
- R6: The staging store holds 4 lines. A new fill into a full store replaces the line that was written longest ago. The replaced line never reaches the main cache, so a later request to it misses.
- R7: The main cache has 16 sets of 2 ways, indexed by line address bits [3:0]. A line entering a full set replaces the least recently used way, and a main-cache hit makes that line the most recently used.
- R8: A main-cache hit is answered one cycle after the request with `resp_hit`=1, `resp_from_main`=1 and the data first delivered by the fill, and it raises no miss.
- R9: `resp_valid` is 1 only in the cycle after a hitting request was accepted or a fill was accepted. Otherwise it is 0.
- R10: Two byte addresses that differ only in bits [5:0] refer to the same line.
- R11: A line is never present in both stores at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Request accepted this cycle when high (state `S_IDLE`) |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | 1 when the response came from a hit |
| resp_from_main | output | 1 | 1 when the hit was in the main cache |
| resp_data | output | 32 | Line data returned |
| miss_valid | output | 1 | Fetch request to the next level |
| miss_line | output | 26 | Line address to fetch |
| fill_valid | input | 1 | Fill data from the next level is present |
| fill_data | input | 32 | Fill data |

## Verification
The assertions take for granted that `fill_valid` is raised only while `miss_valid` is high and that `req_valid` is meaningful only when `req_ready` is high. Under those conditions, the "no line in both stores" property and the response-origin properties are well defined. The stimulus drives one request at a time and raises `fill_valid` for exactly one cycle, only after the miss has been seen. It never sends a request during a fill, and it gives each line a fixed data word so that the data returned on a hit can be predicted.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int unsigned FC_ADDR_W    = 32;
    localparam int unsigned FC_OFFSET_W  = 6;
    localparam int unsigned FC_DATA_W    = 32;
    localparam int unsigned FC_STAGE_N   = 4;
    localparam int unsigned FC_MAIN_SETS = 16;
    localparam int unsigned FC_MAIN_WAYS = 2;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_FILL = 1'b1
    } fc_state_e;
endpackage

// File: rtl/fc_stage_store.sv
module fc_stage_store #(
    parameter int unsigned LINE_W  = 26,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              drop_en,
    input  logic              put_en,
    input  logic [LINE_W-1:0] put_line,
    input  logic [DATA_W-1:0] put_data
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] live_q;
    logic [LINE_W-1:0]  line_q [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [IDX_W-1:0]   rank_q [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]   match_idx;
    logic [IDX_W-1:0]   slot;
    logic               slot_found;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = live_q[g] && (line_q[g] == lk_line);
    end

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

    assign lk_hit  = |match_vec;
    assign lk_data = data_q[match_idx];

    // slot choice: lowest free entry, else the entry with the oldest rank
    always_comb begin
        slot       = '0;
        slot_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!slot_found && !live_q[i]) begin
                slot       = IDX_W'(i);
                slot_found = 1'b1;
            end
        end
        if (!slot_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (rank_q[i] == IDX_W'(ENTRIES - 1)) slot = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
        end else begin
            if (drop_en) live_q[match_idx] <= 1'b0;
            if (put_en) begin
                live_q[slot] <= 1'b1;
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == slot)          rank_q[i] <= '0;
                    else if (rank_q[i] < rank_q[slot]) rank_q[i] <= rank_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (put_en) begin
            line_q[slot] <= put_line;
            data_q[slot] <= put_data;
        end
    end
endmodule

// File: rtl/fc_main_store.sv
module fc_main_store #(
    parameter int unsigned LINE_W = 26,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              touch_en,
    input  logic              put_en,
    input  logic [LINE_W-1:0] put_line,
    input  logic [DATA_W-1:0] put_data
);
    localparam int unsigned WAYS  = fc_pkg::FC_MAIN_WAYS;
    localparam int unsigned SET_W = $clog2(SETS);
    localparam int unsigned TAG_W = LINE_W - SET_W;

    logic [TAG_W-1:0]  tag_q [SETS][WAYS];
    logic [DATA_W-1:0] dat_q [SETS][WAYS];
    logic [WAYS-1:0]   vld_q [SETS];
    logic [SETS-1:0]   old_q;

    logic [SET_W-1:0]  lk_set, put_set;
    logic [TAG_W-1:0]  lk_tag, put_tag;
    logic [WAYS-1:0]   way_hit;
    logic              hit_way;
    logic              put_way;

    assign lk_set  = lk_line[SET_W-1:0];
    assign lk_tag  = lk_line[LINE_W-1:SET_W];
    assign put_set = put_line[SET_W-1:0];
    assign put_tag = put_line[LINE_W-1:SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign lk_hit  = |way_hit;
    assign hit_way = way_hit[1];
    assign lk_data = dat_q[lk_set][hit_way];
    assign put_way = old_q[put_set];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            if (touch_en) old_q[lk_set] <= ~hit_way;
            if (put_en) begin
                vld_q[put_set][put_way] <= 1'b1;
                old_q[put_set]          <= ~put_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (put_en) begin
            tag_q[put_set][put_way] <= put_tag;
            dat_q[put_set][put_way] <= put_data;
        end
    end
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int unsigned LINE_W = 26,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    input  logic              stage_hit,
    input  logic [DATA_W-1:0] stage_data,
    input  logic              main_hit,
    input  logic [DATA_W-1:0] main_data,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              req_ready,
    output logic              stage_drop,
    output logic              stage_put,
    output logic [LINE_W-1:0] stage_put_line,
    output logic              main_touch,
    output logic              main_put,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_from_main,
    output logic [DATA_W-1:0] resp_data,
    output logic              miss_valid,
    output logic [LINE_W-1:0] miss_line
);
    fc_state_e state_q, state_d;
    logic      take;
    logic      any_hit;

    assign req_ready = (state_q == S_IDLE);
    assign take      = req_valid && req_ready;
    assign any_hit   = stage_hit || main_hit;

    assign stage_drop     = take && stage_hit;
    assign main_put       = take && stage_hit;
    assign main_touch     = take && main_hit;
    assign stage_put      = (state_q == S_FILL) && fill_valid;
    assign stage_put_line = miss_line;
    assign miss_valid     = (state_q == S_FILL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take && !any_hit) state_d = S_FILL;
            S_FILL: if (fill_valid)       state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_hit       <= 1'b0;
            resp_from_main <= 1'b0;
            resp_data      <= '0;
            miss_line      <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (take && any_hit) begin
                        resp_valid     <= 1'b1;
                        resp_hit       <= 1'b1;
                        resp_from_main <= main_hit;
                        resp_data      <= main_hit ? main_data : stage_data;
                    end else if (take) begin
                        miss_line <= req_line;
                    end
                end
                S_FILL: begin
                    if (fill_valid) begin
                        resp_valid     <= 1'b1;
                        resp_hit       <= 1'b0;
                        resp_from_main <= 1'b0;
                        resp_data      <= fill_data;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/reuse_filter_cache.sv
module reuse_filter_cache
    import fc_pkg::*;
#(
    parameter int unsigned ADDR_W   = FC_ADDR_W,
    parameter int unsigned OFFSET_W = FC_OFFSET_W,
    parameter int unsigned DATA_W   = FC_DATA_W,
    parameter int unsigned STAGE_N  = FC_STAGE_N,
    parameter int unsigned SETS     = FC_MAIN_SETS,
    localparam int unsigned LINE_W  = ADDR_W - OFFSET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_from_main,
    output logic [DATA_W-1:0] resp_data,
    output logic              miss_valid,
    output logic [LINE_W-1:0] miss_line,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    logic [LINE_W-1:0] req_line;
    logic              offset_unused;
    logic              stage_hit, main_hit;
    logic [DATA_W-1:0] stage_data, main_data;
    logic              stage_drop, stage_put, main_touch, main_put;
    logic [LINE_W-1:0] stage_put_line;

    assign req_line      = req_addr[ADDR_W-1:OFFSET_W];
    assign offset_unused = ^req_addr[OFFSET_W-1:0];

    fc_stage_store #(.LINE_W(LINE_W), .DATA_W(DATA_W), .ENTRIES(STAGE_N)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_line  (req_line),
        .lk_hit   (stage_hit),
        .lk_data  (stage_data),
        .drop_en  (stage_drop),
        .put_en   (stage_put),
        .put_line (stage_put_line),
        .put_data (fill_data)
    );

    fc_main_store #(.LINE_W(LINE_W), .DATA_W(DATA_W), .SETS(SETS)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_line  (req_line),
        .lk_hit   (main_hit),
        .lk_data  (main_data),
        .touch_en (main_touch),
        .put_en   (main_put),
        .put_line (req_line),
        .put_data (stage_data)
    );

    fc_ctrl #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_line       (req_line),
        .stage_hit      (stage_hit),
        .stage_data     (stage_data),
        .main_hit       (main_hit),
        .main_data      (main_data),
        .fill_valid     (fill_valid),
        .fill_data      (fill_data),
        .req_ready      (req_ready),
        .stage_drop     (stage_drop),
        .stage_put      (stage_put),
        .stage_put_line (stage_put_line),
        .main_touch     (main_touch),
        .main_put       (main_put),
        .resp_valid     (resp_valid),
        .resp_hit       (resp_hit),
        .resp_from_main (resp_from_main),
        .resp_data      (resp_data),
        .miss_valid     (miss_valid),
        .miss_line      (miss_line)
    );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int unsigned LINE_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LINE_W-1:0] req_line,
    input logic              stage_hit,
    input logic              main_hit,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_from_main,
    input logic              miss_valid,
    input logic [LINE_W-1:0] miss_line,
    input logic              fill_valid
);
    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(stage_hit && main_hit)); // R11

    AST_MISS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !stage_hit && !main_hit)
        |=> (miss_valid && miss_line == $past(req_line))); // R2

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !fill_valid) |=> (miss_valid && $stable(miss_line))); // R2

    AST_NO_TAKE_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> !req_ready); // R2

    AST_FILL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && fill_valid) |=> (resp_valid && !resp_hit && !miss_valid)); // R3

    AST_HIT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (stage_hit || main_hit))
        |=> (resp_valid && resp_hit && resp_from_main == $past(main_hit))); // R4

    AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(req_valid && req_ready && (stage_hit || main_hit))
                        || $past(miss_valid && fill_valid))); // R9
endmodule

bind reuse_filter_cache fc_checker #(.LINE_W(LINE_W)) u_fc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_line       (req_line),
    .stage_hit      (stage_hit),
    .main_hit       (main_hit),
    .resp_valid     (resp_valid),
    .resp_hit       (resp_hit),
    .resp_from_main (resp_from_main),
    .miss_valid     (miss_valid),
    .miss_line      (miss_line),
    .fill_valid     (fill_valid)
);

// File: tb/tb_reuse_filter_cache.sv
module tb_reuse_filter_cache;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          req_ready, resp_valid, resp_hit, resp_from_main, miss_valid;
    logic [31:0]   resp_data;
    logic [LW-1:0] miss_line;
    logic          fill_valid = 1'b0;
    logic [31:0]   fill_data = '0;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // reference state: queues ordered most recent first
    logic [LW-1:0] stq [$];
    logic [LW-1:0] mq [16][$];

    reuse_filter_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_from_main(resp_from_main), .resp_data(resp_data),
        .miss_valid(miss_valid), .miss_line(miss_line),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] line_word(logic [LW-1:0] l);
        return {6'h2B, l} ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    // kind: 0 miss, 1 staging hit, 2 main hit
    function automatic int model_step(logic [LW-1:0] l);
        int s = int'(l[3:0]);
        foreach (mq[s][i]) begin
            if (mq[s][i] == l) begin
                mq[s].delete(i);
                mq[s].push_front(l);
                return 2;
            end
        end
        foreach (stq[i]) begin
            if (stq[i] == l) begin
                stq.delete(i);
                mq[s].push_front(l);
                if (mq[s].size() > 2) void'(mq[s].pop_back());
                return 1;
            end
        end
        stq.push_front(l);
        if (stq.size() > 4) void'(stq.pop_back());
        return 0;
    endfunction

    // exp_kind < 0: take the reference model's answer
    task automatic access(logic [31:0] addr, int exp_kind, string req);
        logic [LW-1:0] l = addr[31:6];
        int mk = model_step(l);
        int k  = (exp_kind < 0) ? mk : exp_kind;
        chk({req, " ready"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = addr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (k == 0) begin
            chk({req, " R2 miss_valid"}, 32'(miss_valid), 32'd1);
            chk({req, " R2 miss_line"}, 32'(miss_line), 32'(l));
            chk({req, " R2 ready low"}, 32'(req_ready), 32'd0);
            chk({req, " R9 no resp"}, 32'(resp_valid), 32'd0);
            fill_valid = 1'b1;
            fill_data  = line_word(l);
            @(posedge clk);
            @(negedge clk);
            fill_valid = 1'b0;
            chk({req, " R3 resp_valid"}, 32'(resp_valid), 32'd1);
            chk({req, " R3 resp_hit"}, 32'(resp_hit), 32'd0);
            chk({req, " R3 data"}, resp_data, line_word(l));
            chk({req, " R3 miss drop"}, 32'(miss_valid), 32'd0);
        end else begin
            chk({req, " R9 resp_valid"}, 32'(resp_valid), 32'd1);
            chk({req, " R4 resp_hit"}, 32'(resp_hit), 32'd1);
            chk({req, " R8 from_main"}, 32'(resp_from_main), (k == 2) ? 32'd1 : 32'd0);
            chk({req, " R8 data"}, resp_data, line_word(l));
            chk({req, " R8 no miss"}, 32'(miss_valid), 32'd0);
        end
    endtask

    function automatic logic [31:0] ad(logic [LW-1:0] l, logic [5:0] off);
        return {l, off};
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 resp_valid", 32'(resp_valid), 32'd0);
        chk("R1 miss_valid", 32'(miss_valid), 32'd0);

        // R1 first access misses; R10 offset ignored; R3/R4/R8 path
        access(ad(26'h40, 6'h00), 0, "R1 first");
        access(ad(26'h40, 6'h3C), 1, "R10 same line");
        access(ad(26'h40, 6'h11), 2, "R8 main");
        @(negedge clk);
        chk("R9 pulse ends", 32'(resp_valid), 32'd0);

        // R6 staging LRU: five fills, oldest dropped
        access(ad(26'h81, 0), 0, "R6 b");
        access(ad(26'h82, 0), 0, "R6 c");
        access(ad(26'h83, 0), 0, "R6 d");
        access(ad(26'h84, 0), 0, "R6 e");
        access(ad(26'h86, 0), 0, "R6 f");
        access(ad(26'h81, 0), 0, "R6 evicted misses");
        // R5 freed slot: promote d, fill g, e still parked
        access(ad(26'h83, 6'h08), 1, "R5 promote");
        access(ad(26'h87, 0), 0, "R5 g");
        access(ad(26'h84, 0), 1, "R5 e kept");
        access(ad(26'h86, 0), 1, "R5 f kept");

        // R7 main set 5 LRU
        access(ad(26'h405, 0), 0, "R7 p1");
        access(ad(26'h405, 0), 1, "R7 p1 up");
        access(ad(26'h415, 0), 0, "R7 p2");
        access(ad(26'h415, 0), 1, "R7 p2 up");
        access(ad(26'h405, 0), 2, "R7 p1 touch");
        access(ad(26'h425, 0), 0, "R7 p3");
        access(ad(26'h425, 0), 1, "R7 p3 up");
        access(ad(26'h415, 0), 0, "R7 p2 evicted");
        access(ad(26'h405, 0), 2, "R7 p1 kept");

        // mixed pattern, reference model decides (R11 exclusivity implied)
        for (int n = 0; n < 400; n++) begin
            logic [LW-1:0] l = 26'h1000 + 26'((n * 7 + n / 5) % 23) * 26'h10 + 26'(n % 3);
            access(ad(l, 6'(n)), -1, "R11 mixed");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule